// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block regulates how many instructions move from the decode side of a pipeline into the rename side each cycle. An upstream group of up to `WIDTH` instructions arrives with a valid count. The block passes on as many as the downstream structures can take: the smaller of the free reorder-buffer slots and the free issue-queue slots. Instructions that cannot go on are held in a local skid buffer, and a stall signal tells the upstream stage to stop sending.

The controller is a four-state machine. The states are RUN (normal flow), BLOCK (downstream full, arrivals are parked), UNBLK (draining the skid buffer oldest first), and SQUASH (a flush is in progress, arrivals are thrown away). The transitions are:

- RUN→BLOCK when an incoming group does not fit.
- BLOCK→UNBLK on a downstream unblock indication.
- UNBLK→RUN once the skid buffer is empty.
- any state→SQUASH when a squash request is raised.
- SQUASH→RUN in the cycle after the squash request drops.

Eight counters tally the following:

- cycles spent in each of squash, idle, blocked and unblocking;
- instructions passed on;
- instructions squashed;
- full events charged to each downstream structure.

Top module: `rename_flow_ctl`

## Requirements
- R1: While reset is low and right after it is released, `out_count` is 0, `stall_up` is 0, every counter reads 0 and the state is RUN.
- R2: In RUN, the group passed on is the first min(`in_count`, `rob_free`, `iq_free`) lanes of `in_data`. It appears on `out_count`/`out_data` one clock later, with lane 0 holding the oldest instruction.
- R3: In RUN with `in_count` > 0 and min(`rob_free`, `iq_free`) = 0, nothing passes, the whole group enters the skid buffer, the state moves to BLOCK and `stall_up` rises one clock later. The full event is counted on `cnt_rob_full` if `rob_free` is 0, else on `cnt_iq_full`.
- R4: In RUN with 0 < min(`rob_free`, `iq_free`) < `in_count`, only the minimum passes, the rest enters the skid buffer in lane order, and the state moves to BLOCK. The full event is counted on `cnt_rob_full` when `rob_free` < `iq_free`, else on `cnt_iq_full`.
- R5: In BLOCK, nothing passes (`out_count` 0 next clock), every arrival is appended to the skid buffer, and `unblock_req` moves the state to UNBLK.
- R6: In UNBLK, up to min(`rob_free`, `iq_free`, `WIDTH`) instructions leave the skid buffer each clock, oldest first, and arrivals are appended behind them. `stall_up` stays 1 until the buffer is empty, then the state returns to RUN and `stall_up` falls.
- R7: `squash_req` wins over every other transition. It empties the skid buffer, drives `out_count` to 0 and `stall_up` to 0 next clock, and discards the presented group, adding `in_count` to `cnt_squashed`. The state returns to RUN the clock after `squash_req` drops, and no instruction parked before the squash is ever passed on.
- R8: `cnt_squash_cyc`, `cnt_block_cyc` and `cnt_unblk_cyc` increase by one for each clock spent in SQUASH, BLOCK and UNBLK respectively. `cnt_idle_cyc` increases for each clock in RUN with `in_count` 0 and no squash request.
- R9: `cnt_renamed` increases by exactly the `out_count` value that appears at the same clock edge.
- R10: The skid buffer holds `WIDTH`×`UP_DELAY` entries; an upstream that stops within `UP_DELAY` clocks of `stall_up` never overflows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_count | input | CW | Number of valid lanes in `in_data` (0..WIDTH) |
| in_data | input | WIDTH*PAYLOAD_W | Incoming group, lane 0 oldest |
| rob_free | input | FREE_W | Free reorder-buffer slots |
| iq_free | input | FREE_W | Free issue-queue slots |
| squash_req | input | 1 | Flush request, highest priority |
| unblock_req | input | 1 | Downstream has room again |
| out_count | output | CW | Number of valid lanes passed on |
| out_data | output | WIDTH*PAYLOAD_W | Group passed on, lane 0 oldest |
| stall_up | output | 1 | Tells the upstream stage to stop sending |
| cnt_squash_cyc | output | CNT_W | Clocks spent squashing |
| cnt_idle_cyc | output | CNT_W | Clocks running with no input |
| cnt_block_cyc | output | CNT_W | Clocks blocked |
| cnt_unblk_cyc | output | CNT_W | Clocks unblocking |
| cnt_renamed | output | CNT_W | Instructions passed on |
| cnt_squashed | output | CNT_W | Instructions discarded by squash |
| cnt_rob_full | output | CNT_W | Full events charged to the reorder buffer |
| cnt_iq_full | output | CNT_W | Full events charged to the issue queue |

## Verification
A wrong state or a corrupt skid pointer shows at the ports within one or two clocks. Possible symptoms are an instruction tag that appears out of order or twice, a `stall_up` that falls while parked work remains, or a group that passes while the block should be holding. The bench tags every lane with a unique value, so ordering and loss can be seen directly on `out_data`. Counter deltas taken across the whole sequence expose any cycle that was charged to the wrong state.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_BLOCK  = 2'd1,
        ST_UNBLK  = 2'd2,
        ST_SQUASH = 2'd3
    } rfc_state_e;

    localparam int CI_SQUASH_CYC = 0;
    localparam int CI_IDLE_CYC   = 1;
    localparam int CI_BLOCK_CYC  = 2;
    localparam int CI_UNBLK_CYC  = 3;
    localparam int CI_RENAMED    = 4;
    localparam int CI_SQUASHED   = 5;
    localparam int CI_ROB_FULL   = 6;
    localparam int CI_IQ_FULL    = 7;
    localparam int NUM_CNT       = 8;

endpackage

// File: rtl/rfc_admit.sv
`timescale 1ns/1ps
// Combinational admission limit: how many of the available instructions
// fit downstream, whether some are left over, and whom to charge for it.
module rfc_admit #(
    parameter  int WIDTH  = 4,
    parameter  int FREE_W = 5,
    localparam int CW     = $clog2(WIDTH + 1)
) (
    input  logic [CW-1:0]     avail,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    output logic [CW-1:0]     lim,
    output logic [CW-1:0]     take,
    output logic              short_fall,
    output logic              charge_rob
);

    logic [FREE_W-1:0] room;

    always_comb begin
        room = (rob_free < iq_free) ? rob_free : iq_free;
        if (int'(room) > WIDTH) begin
            lim = CW'(WIDTH);
        end else begin
            lim = CW'(room);
        end
        take       = (avail < lim) ? avail : lim;
        short_fall = (avail > lim);
        if (room == '0) begin
            charge_rob = (rob_free == '0);
        end else begin
            charge_rob = (rob_free < iq_free);
        end
    end

endmodule

// File: rtl/rfc_skid.sv
`timescale 1ns/1ps
// Circular skid buffer with multi-entry push and pop per clock.
module rfc_skid #(
    parameter  int WIDTH     = 4,
    parameter  int PAYLOAD_W = 8,
    parameter  int DEPTH     = 8,
    localparam int CW        = $clog2(WIDTH + 1),
    localparam int SCW       = $clog2(DEPTH + 1),
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [CW-1:0]              push_n,
    input  logic [CW-1:0]              push_off,
    input  logic [WIDTH*PAYLOAD_W-1:0] push_data,
    input  logic [CW-1:0]              pop_n,
    output logic [SCW-1:0]             count,
    output logic [WIDTH*PAYLOAD_W-1:0] peek
);

    logic [PAYLOAD_W-1:0] mem [DEPTH];
    logic [PAYLOAD_W-1:0] lane_in [WIDTH];
    logic [PTR_W-1:0]     head_q;
    logic [PTR_W-1:0]     tail_q;
    logic [SCW-1:0]       count_q;

    function automatic logic [PTR_W-1:0] wrap(input int v);
        return PTR_W'(v % DEPTH);
    endfunction

    // Shift incoming lanes so that lane push_off lands in slot 0.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            int src;
            src = int'(push_off) + i;
            if (src < WIDTH) begin
                lane_in[i] = push_data[src*PAYLOAD_W +: PAYLOAD_W];
            end else begin
                lane_in[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !clear) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i < int'(push_n)) begin
                    mem[wrap(int'(tail_q) + i)] <= lane_in[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= wrap(int'(head_q) + int'(pop_n));
            tail_q  <= wrap(int'(tail_q) + int'(push_n));
            count_q <= count_q + SCW'(push_n) - SCW'(pop_n);
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            peek[i*PAYLOAD_W +: PAYLOAD_W] = mem[wrap(int'(head_q) + i)];
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rfc_counter.sv
`timescale 1ns/1ps
// Wrapping event counter with a variable increment.
module rfc_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_q + CNT_W'(inc);
        end
    end

    assign value = value_q;

endmodule

// File: rtl/rename_flow_ctl.sv
`timescale 1ns/1ps
module rename_flow_ctl
    import rfc_pkg::*;
#(
    parameter  int WIDTH     = 4,
    parameter  int PAYLOAD_W = 8,
    parameter  int UP_DELAY  = 2,
    parameter  int FREE_W    = 5,
    parameter  int CNT_W     = 16,
    localparam int CW        = $clog2(WIDTH + 1),
    localparam int DW        = WIDTH * PAYLOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     in_count,
    input  logic [DW-1:0]     in_data,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    input  logic              squash_req,
    input  logic              unblock_req,
    output logic [CW-1:0]     out_count,
    output logic [DW-1:0]     out_data,
    output logic              stall_up,
    output logic [CNT_W-1:0]  cnt_squash_cyc,
    output logic [CNT_W-1:0]  cnt_idle_cyc,
    output logic [CNT_W-1:0]  cnt_block_cyc,
    output logic [CNT_W-1:0]  cnt_unblk_cyc,
    output logic [CNT_W-1:0]  cnt_renamed,
    output logic [CNT_W-1:0]  cnt_squashed,
    output logic [CNT_W-1:0]  cnt_rob_full,
    output logic [CNT_W-1:0]  cnt_iq_full
);

    localparam int DEPTH = WIDTH * UP_DELAY;
    localparam int SCW   = $clog2(DEPTH + 1);

    rfc_state_e st_q, st_d;

    logic [CW-1:0]    avail_sel;
    logic [CW-1:0]    skid_avail;
    logic [CW-1:0]    lim, take;
    logic             short_fall, charge_rob;

    logic [CW-1:0]    push_n, push_off, pop_n, emit_n;
    logic             clr, emit_skid;
    logic [SCW-1:0]   skid_count;
    logic [DW-1:0]    skid_peek;

    logic [CW-1:0]    inc_v [NUM_CNT];
    logic [CNT_W-1:0] cnt_v [NUM_CNT];

    logic [CW-1:0]    out_count_q;
    logic [DW-1:0]    out_data_q;

    // Number of parked entries the drain may consider this clock.
    assign skid_avail = (int'(skid_count) > WIDTH) ? CW'(WIDTH) : CW'(skid_count);
    assign avail_sel  = (st_q == ST_UNBLK) ? skid_avail : in_count;

    rfc_admit #(
        .WIDTH (WIDTH),
        .FREE_W(FREE_W)
    ) u_admit (
        .avail     (avail_sel),
        .rob_free  (rob_free),
        .iq_free   (iq_free),
        .lim       (lim),
        .take      (take),
        .short_fall(short_fall),
        .charge_rob(charge_rob)
    );

    rfc_skid #(
        .WIDTH    (WIDTH),
        .PAYLOAD_W(PAYLOAD_W),
        .DEPTH    (DEPTH)
    ) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr),
        .push_n   (push_n),
        .push_off (push_off),
        .push_data(in_data),
        .pop_n    (pop_n),
        .count    (skid_count),
        .peek     (skid_peek)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state, buffer control and counter increments.
    always_comb begin
        st_d      = st_q;
        push_n    = '0;
        push_off  = '0;
        pop_n     = '0;
        clr       = 1'b0;
        emit_n    = '0;
        emit_skid = 1'b0;
        for (int k = 0; k < NUM_CNT; k++) begin
            inc_v[k] = '0;
        end

        unique case (st_q)
            ST_RUN: begin
                emit_n = take;
                if (in_count == '0) begin
                    inc_v[CI_IDLE_CYC] = CW'(1);
                end
                if (short_fall) begin
                    push_n   = in_count - take;
                    push_off = take;
                    st_d     = ST_BLOCK;
                    if (charge_rob) begin
                        inc_v[CI_ROB_FULL] = CW'(1);
                    end else begin
                        inc_v[CI_IQ_FULL] = CW'(1);
                    end
                end
            end
            ST_BLOCK: begin
                inc_v[CI_BLOCK_CYC] = CW'(1);
                push_n = in_count;
                if (unblock_req) begin
                    st_d = ST_UNBLK;
                end
            end
            ST_UNBLK: begin
                inc_v[CI_UNBLK_CYC] = CW'(1);
                emit_n    = take;
                emit_skid = 1'b1;
                pop_n     = take;
                push_n    = in_count;
                if ((int'(skid_count) + int'(in_count) - int'(take)) == 0) begin
                    st_d = ST_RUN;
                end
            end
            ST_SQUASH: begin
                inc_v[CI_SQUASH_CYC] = CW'(1);
                if (!squash_req) begin
                    st_d = ST_RUN;
                end
            end
        endcase

        // Squash overrides every other transition.
        if (squash_req) begin
            st_d               = ST_SQUASH;
            clr                = 1'b1;
            push_n             = '0;
            pop_n              = '0;
            emit_n             = '0;
            emit_skid          = 1'b0;
            inc_v[CI_IDLE_CYC] = '0;
            inc_v[CI_ROB_FULL] = '0;
            inc_v[CI_IQ_FULL]  = '0;
        end
        if (squash_req || st_q == ST_SQUASH) begin
            inc_v[CI_SQUASHED] = in_count;
        end
        inc_v[CI_RENAMED] = emit_n;
    end

    // Registered output group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_count_q <= '0;
            out_data_q  <= '0;
        end else begin
            out_count_q <= emit_n;
            for (int i = 0; i < WIDTH; i++) begin
                if (i < int'(emit_n)) begin
                    out_data_q[i*PAYLOAD_W +: PAYLOAD_W] <= emit_skid ?
                        skid_peek[i*PAYLOAD_W +: PAYLOAD_W] :
                        in_data[i*PAYLOAD_W +: PAYLOAD_W];
                end else begin
                    out_data_q[i*PAYLOAD_W +: PAYLOAD_W] <= '0;
                end
            end
        end
    end

    assign out_count = out_count_q;
    assign out_data  = out_data_q;
    assign stall_up  = (st_q == ST_BLOCK) || (st_q == ST_UNBLK);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rfc_counter #(
            .CNT_W(CNT_W),
            .INC_W(CW)
        ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_v[g]),
            .value(cnt_v[g])
        );
    end

    assign cnt_squash_cyc = cnt_v[CI_SQUASH_CYC];
    assign cnt_idle_cyc   = cnt_v[CI_IDLE_CYC];
    assign cnt_block_cyc  = cnt_v[CI_BLOCK_CYC];
    assign cnt_unblk_cyc  = cnt_v[CI_UNBLK_CYC];
    assign cnt_renamed    = cnt_v[CI_RENAMED];
    assign cnt_squashed   = cnt_v[CI_SQUASHED];
    assign cnt_rob_full   = cnt_v[CI_ROB_FULL];
    assign cnt_iq_full    = cnt_v[CI_IQ_FULL];

endmodule

// File: rtl/rename_flow_chk.sv
`timescale 1ns/1ps
module rename_flow_chk
    import rfc_pkg::*;
#(
    parameter  int WIDTH  = 4,
    parameter  int FREE_W = 5,
    parameter  int CNT_W  = 16,
    parameter  int DEPTH  = 8,
    localparam int CW     = $clog2(WIDTH + 1),
    localparam int SCW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     in_count,
    input logic [FREE_W-1:0] rob_free,
    input logic [FREE_W-1:0] iq_free,
    input logic              squash_req,
    input logic [CW-1:0]     out_count,
    input logic              stall_up,
    input logic [CNT_W-1:0]  cnt_renamed,
    input rfc_state_e        st_q,
    input logic [SCW-1:0]    skid_count,
    input logic [CW-1:0]     push_n,
    input logic [CW-1:0]     pop_n
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(skid_count) + int'(push_n) - int'(pop_n)) <= DEPTH); // R10

    AST_ADMIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !squash_req) |=>
            (out_count <= $past(in_count) && out_count <= $past(rob_free)
             && out_count <= $past(iq_free))); // R2

    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !squash_req && in_count != '0
         && (rob_free == '0 || iq_free == '0)) |=>
            (out_count == '0 && stall_up)); // R3

    AST_PARTIAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !squash_req
         && (FREE_W'(in_count) > rob_free || FREE_W'(in_count) > iq_free)) |=>
            stall_up); // R4

    AST_BLOCK_NOPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLOCK && !squash_req) |=> (out_count == '0)); // R5

    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_up) |-> ($past(squash_req) || $past(st_q) == ST_UNBLK)); // R6

    AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (out_count == '0 && !stall_up && skid_count == '0)); // R7

    AST_RENAMED_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_renamed == $past(cnt_renamed) + CNT_W'(out_count)); // R9

endmodule

bind rename_flow_ctl rename_flow_chk #(
    .WIDTH (WIDTH),
    .FREE_W(FREE_W),
    .CNT_W (CNT_W),
    .DEPTH (WIDTH * UP_DELAY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_count   (in_count),
    .rob_free   (rob_free),
    .iq_free    (iq_free),
    .squash_req (squash_req),
    .out_count  (out_count),
    .stall_up   (stall_up),
    .cnt_renamed(cnt_renamed),
    .st_q       (st_q),
    .skid_count (skid_count),
    .push_n     (push_n),
    .pop_n      (pop_n)
);

// File: tb/sim_rename_flow_ctl.sv
`timescale 1ns/1ps
module sim_rename_flow_ctl;

    localparam int WIDTH = 4;
    localparam int PW    = 8;
    localparam int FW    = 5;
    localparam int CNTW  = 16;
    localparam int CW    = $clog2(WIDTH + 1);
    localparam int NVEC  = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   in_count = '0;
    logic [WIDTH*PW-1:0] in_data = '0;
    logic [FW-1:0]   rob_free = '0;
    logic [FW-1:0]   iq_free = '0;
    logic            squash_req = 1'b0;
    logic            unblock_req = 1'b0;
    logic [CW-1:0]   out_count;
    logic [WIDTH*PW-1:0] out_data;
    logic            stall_up;
    logic [CNTW-1:0] c_sq, c_idle, c_blk, c_unb, c_ren, c_sqd, c_rob, c_iq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rename_flow_ctl #(
        .WIDTH(WIDTH), .PAYLOAD_W(PW), .UP_DELAY(2), .FREE_W(FW), .CNT_W(CNTW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_data(in_data),
        .rob_free(rob_free), .iq_free(iq_free), .squash_req(squash_req),
        .unblock_req(unblock_req), .out_count(out_count), .out_data(out_data),
        .stall_up(stall_up), .cnt_squash_cyc(c_sq), .cnt_idle_cyc(c_idle),
        .cnt_block_cyc(c_blk), .cnt_unblk_cyc(c_unb), .cnt_renamed(c_ren),
        .cnt_squashed(c_sqd), .cnt_rob_full(c_rob), .cnt_iq_full(c_iq)
    );

    // sq, ub, n, rob, iq, expected count, expected lane-0 tag, expected stall
    typedef struct packed {
        logic       sq;
        logic       ub;
        logic [2:0] n;
        logic [4:0] rob;
        logic [4:0] iq;
        logic [2:0] en;
        logic [7:0] ef;
        logic       es;
    } vec_t;

    localparam vec_t VT [NVEC] = '{
        '{1'b0, 1'b0, 3'd3, 5'd8, 5'd8, 3'd3, 8'h00, 1'b0}, // R2 plain pass
        '{1'b0, 1'b0, 3'd4, 5'd2, 5'd5, 3'd2, 8'h10, 1'b1}, // R4 partial, rob charged
        '{1'b0, 1'b0, 3'd2, 5'd0, 5'd0, 3'd0, 8'h00, 1'b1}, // R5 arrivals parked
        '{1'b0, 1'b1, 3'd0, 5'd0, 5'd0, 3'd0, 8'h00, 1'b1}, // R5 unblock
        '{1'b0, 1'b0, 3'd1, 5'd3, 5'd8, 3'd3, 8'h12, 1'b1}, // R6 drain 3
        '{1'b0, 1'b0, 3'd0, 5'd4, 5'd4, 3'd2, 8'h21, 1'b0}, // R6 drain rest
        '{1'b0, 1'b0, 3'd0, 5'd8, 5'd8, 3'd0, 8'h00, 1'b0}, // R8 idle
        '{1'b0, 1'b0, 3'd4, 5'd6, 5'd0, 3'd0, 8'h00, 1'b1}, // R3 iq empty
        '{1'b1, 1'b0, 3'd2, 5'd8, 5'd8, 3'd0, 8'h00, 1'b0}, // R7 squash from block
        '{1'b0, 1'b0, 3'd3, 5'd8, 5'd8, 3'd0, 8'h00, 1'b0}, // R7 discard in squash
        '{1'b0, 1'b0, 3'd4, 5'd8, 5'd8, 3'd4, 8'hA0, 1'b0}, // R2 full width
        '{1'b0, 1'b0, 3'd4, 5'd5, 5'd3, 3'd3, 8'hB0, 1'b1}, // R4 partial, iq charged
        '{1'b0, 1'b1, 3'd0, 5'd8, 5'd8, 3'd0, 8'h00, 1'b1}, // R5 unblock
        '{1'b0, 1'b0, 3'd0, 5'd1, 5'd1, 3'd1, 8'hB3, 1'b0}  // R6 last entry
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic sq, input logic ub, input int n,
                        input int rob, input int iq, input int k);
        @(negedge clk);
        squash_req  = sq;
        unblock_req = ub;
        in_count    = CW'(n);
        rob_free    = FW'(rob);
        iq_free     = FW'(iq);
        for (int i = 0; i < WIDTH; i++) begin
            in_data[i*PW +: PW] = PW'((k % 16) * 16 + i);
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int s_sq, s_idle, s_blk, s_unb, s_ren, s_sqd, s_rob, s_iq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "out_count", int'(out_count), 0);
        check("R1", "stall_up", int'(stall_up), 0);
        check("R1", "cnt_renamed", int'(c_ren), 0);
        check("R1", "cnt_idle_cyc", int'(c_idle), 0);
        @(posedge clk);
        #2;
        s_sq = int'(c_sq); s_idle = int'(c_idle); s_blk = int'(c_blk); s_unb = int'(c_unb);
        s_ren = int'(c_ren); s_sqd = int'(c_sqd); s_rob = int'(c_rob); s_iq = int'(c_iq);

        for (int k = 0; k < NVEC; k++) begin
            step(VT[k].sq, VT[k].ub, int'(VT[k].n), int'(VT[k].rob), int'(VT[k].iq), k);
            check("R2/R3/R4/R5/R6/R7", $sformatf("vec %0d out_count", k),
                  int'(out_count), int'(VT[k].en));
            check("R3/R4/R5/R6/R7", $sformatf("vec %0d stall_up", k),
                  int'(stall_up), int'(VT[k].es));
            if (VT[k].en != '0) begin
                check("R2/R6", $sformatf("vec %0d lane0 tag", k),
                      int'(out_data[PW-1:0]), int'(VT[k].ef));
            end
            if (k == 4) begin
                check("R6", "vec 4 lane2 tag", int'(out_data[3*PW-1:2*PW]), 'h20);
            end
        end

        check("R8", "squash cycles", int'(c_sq) - s_sq, 1);
        check("R8", "idle cycles", int'(c_idle) - s_idle, 1);
        check("R8", "block cycles", int'(c_blk) - s_blk, 4);
        check("R8", "unblock cycles", int'(c_unb) - s_unb, 3);
        check("R9", "renamed", int'(c_ren) - s_ren, 18);
        check("R7", "squashed", int'(c_sqd) - s_sqd, 5);
        check("R4", "rob full events", int'(c_rob) - s_rob, 1);
        check("R3", "iq full events", int'(c_iq) - s_iq, 2);

        // R3: both structures empty charges the reorder buffer
        s_rob = int'(c_rob); s_iq = int'(c_iq);
        step(1'b0, 1'b0, 2, 0, 0, 12);
        check("R3", "both-zero out_count", int'(out_count), 0);
        check("R3", "both-zero stall_up", int'(stall_up), 1);
        check("R3", "both-zero rob charge", int'(c_rob) - s_rob, 1);
        check("R3", "both-zero iq untouched", int'(c_iq) - s_iq, 0);
        step(1'b0, 1'b1, 0, 8, 8, 13);
        check("R5", "unblock keeps stall", int'(stall_up), 1);
        step(1'b0, 1'b0, 0, 8, 8, 14);
        check("R6", "drain count", int'(out_count), 2);
        check("R6", "drain lane0", int'(out_data[PW-1:0]), 'hC0);
        check("R6", "drain lane1", int'(out_data[2*PW-1:PW]), 'hC1);
        check("R6", "stall released", int'(stall_up), 0);

        // R7: squash during unblocking drops parked entries
        step(1'b0, 1'b0, 4, 1, 1, 1);
        check("R4", "single admit", int'(out_count), 1);
        step(1'b0, 1'b1, 0, 8, 8, 2);
        check("R5", "to unblocking stall", int'(stall_up), 1);
        step(1'b1, 1'b0, 0, 8, 8, 3);
        check("R7", "squash out_count", int'(out_count), 0);
        check("R7", "squash stall", int'(stall_up), 0);
        step(1'b0, 1'b0, 0, 8, 8, 4);
        check("R7", "leaving squash out_count", int'(out_count), 0);
        step(1'b0, 1'b0, 2, 8, 8, 5);
        check("R7", "fresh group count", int'(out_count), 2);
        check("R7", "no stale entry", int'(out_data[PW-1:0]), 'h50);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule